// File: doc/BRIEF.md
# Programmable Parallel Port, Basic Mode

A byte-wide peripheral with three 8-bit ports (A, B and C) and a control register, reached over a simple processor bus. The bus has a chip select, active-low read and write strobes, a two-bit register select and split 8-bit data paths: one for data in and one for data out, plus an output enable for the data out path. Port C is split into an upper nibble (bits 7:4) and a lower nibble (bits 3:0), and each nibble has its own direction.

A write to the control register is decoded by its top bit. When bit 7 is 1, the byte is a direction word. When bit 7 is 0, the byte is a single-bit command that sets or clears one bit of port C. Output ports drive latched values on their pins and assert their output enables. Input ports return the live pin values when read.

Only the plain input/output mode is built. The mode-select fields of the direction word are ignored.

Top module: `ppi_mode0`

## Requirements
- R1: After reset, all four port sections are inputs, all output enables are low, all latches are zero, and the control register reads 9BH.
- R2: A control write with bit 7 = 1 sets the directions from four bits, where 1 means input: bit 4 sets port A, bit 3 sets upper C, bit 1 sets port B and bit 0 sets lower C. Each output enable is all ones while its section is an output, and zero while it is an input.
- R3: A control write with bit 7 = 0 sets port C latch bit d[3:1] to d[0] and leaves the other seven bits unchanged. For example, 0AH clears bit 5.
- R4: A direction word clears the A, B and C latches to zero.
- R5: Register select 00, 01, 10 and 11 address port A, port B, port C and the control register. A write to a port loads its latch whatever that port's direction is.
- R6: A set/reset command leaves the directions and the control readback unchanged.
- R7: A read of an input section returns its pins. A read of an output section returns its latch. For port C this applies to each nibble on its own.
- R8: Reading the control register returns the last direction word, with bit 7 = 1 and bits 6, 5 and 2 read as 0. The control word 92H reads back 92H and makes A and B inputs and both C halves outputs.
- R9: The data out enable is high only while chip select is high and the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Register select |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_oe | output | 1 | Read data enable |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A drive enable |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B drive enable |
| pc_in | input | 8 | Port C pins |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C drive enable, per nibble |

## Verification
A write is captured at the first rising edge while chip select is high and the write strobe is low. The new latch, direction and enable values are therefore due one edge after the strobe is driven. The bench drives the strobe on a falling edge, releases it on the next falling edge, and only then samples the outputs. Reads are combinational, so the bench drives select and the read strobe and samples dout a nanosecond later within the same low phase. The pins are swept with values that differ from the latches, so that a wrong pin-or-latch choice shows up.

// File: rtl/ppi_mode0.sv
module ppi_mode0 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int H = W / 2;

  logic       in_a, in_b, in_cu, in_cl;
  logic [W-1:0] lat_a, lat_b, lat_c;

  wire wr_en  = cs && !wr_n;
  wire rd_en  = cs && !rd_n;
  wire ctl_wr = wr_en && (sel == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {in_a, in_cu, in_b, in_cl} <= 4'b1111;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (wr_en) begin
      case (sel)
        2'b00: lat_a <= din;
        2'b01: lat_b <= din;
        2'b10: lat_c <= din;
        default:
          if (din[7]) begin
            {in_a, in_cu, in_b, in_cl} <= {din[4], din[3], din[1], din[0]};
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end else begin
            lat_c[din[3:1]] <= din[0];
          end
      endcase
    end
  end

  wire [W-1:0] ctl_rd = {1'b1, 2'b00, in_a, in_cu, 1'b0, in_b, in_cl};
  wire [W-1:0] c_rd   = {in_cu ? pc_in[W-1:H] : lat_c[W-1:H],
                         in_cl ? pc_in[H-1:0] : lat_c[H-1:0]};

  always_comb begin
    case (sel)
      2'b00:   dout = in_a ? pa_in : lat_a;
      2'b01:   dout = in_b ? pb_in : lat_b;
      2'b10:   dout = c_rd;
      default: dout = ctl_rd;
    endcase
  end

  assign dout_oe = rd_en;
  assign pa_out  = lat_a;
  assign pb_out  = lat_b;
  assign pc_out  = lat_c;
  assign pa_oe   = {W{~in_a}};
  assign pb_oe   = {W{~in_b}};
  assign pc_oe   = {{H{~in_cu}}, {H{~in_cl}}};

  AST_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && din[7] |=> (pa_out == '0) && (pb_out == '0) && (pc_out == '0)); // R4
  AST_DIR_A: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && din[7] |=> pa_oe == {W{~$past(din[4])}}); // R2
  AST_BSR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !din[7] |=> pc_out[$past(din[3:1])] == $past(din[0])); // R3
  AST_BSR_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !din[7] |=> ((pc_out ^ $past(pc_out)) & ~(W'(1) << $past(din[3:1]))) == '0); // R3
  AST_BSR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !din[7] |=> $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)); // R6
  AST_RD_IN_A: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sel == 2'b00 && pa_oe == '0 |-> dout == pa_in); // R7
  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> cs && !rd_n); // R9
endmodule

// File: tb/sim_ppi_mode0.sv
module sim_ppi_mode0;
  logic clk = 0, rst_n = 0, cs = 0, rd_n = 1, wr_n = 1;
  logic [1:0] sel = 0;
  logic [7:0] din = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic dout_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ppi_mode0 u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .rd_n(rd_n), .wr_n(wr_n),
    .sel(sel), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr_n = 0; sel = a; din = d;
    @(negedge clk); cs = 0; wr_n = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd_n = 0; sel = a;
    #1; d = dout;
    chk("R9 oe during read", {7'd0, dout_oe}, 8'd1);
    cs = 0; rd_n = 1;
    #1; chk("R9 oe idle", {7'd0, dout_oe}, 8'd0);
  endtask

  logic [7:0] v, la, lb, lc, cw;
  logic da, dcu, db, dcl;

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 0); chk("R1 pb_oe", pb_oe, 0); chk("R1 pc_oe", pc_oe, 0);
    chk("R1 pa_out", pa_out, 0); chk("R1 pb_out", pb_out, 0); chk("R1 pc_out", pc_out, 0);
    rd(2'b11, v); chk("R1 ctl", v, 8'h9B);

    for (int m = 0; m < 16; m++) begin
      da = m[3]; dcu = m[2]; db = m[1]; dcl = m[0];
      // junk in ignored mode fields 6,5,2
      cw = {1'b1, 2'b11, da, dcu, 1'b1, db, dcl};
      wr(2'b00, 8'h5A);
      wr(2'b11, cw);
      chk("R4 A cleared", pa_out, 0); chk("R4 B cleared", pb_out, 0); chk("R4 C cleared", pc_out, 0);
      chk("R2 pa_oe", pa_oe, {8{~da}});
      chk("R2 pb_oe", pb_oe, {8{~db}});
      chk("R2 pc_oe", pc_oe, {{4{~dcu}}, {4{~dcl}}});
      rd(2'b11, v); chk("R8 ctl readback", v, {1'b1, 2'b00, da, dcu, 1'b0, db, dcl});
      la = 8'h11 * m[3:0] ^ 8'hA5; lb = ~la; lc = {la[3:0], lb[7:4]};
      wr(2'b00, la); wr(2'b01, lb); wr(2'b10, lc);
      chk("R5 A latch", pa_out, la); chk("R5 B latch", pb_out, lb); chk("R5 C latch", pc_out, lc);
      pa_in = ~la ^ 8'h3C; pb_in = ~lb ^ 8'hC3; pc_in = ~lc;
      rd(2'b00, v); chk("R7 read A", v, da ? pa_in : la);
      rd(2'b01, v); chk("R7 read B", v, db ? pb_in : lb);
      rd(2'b10, v); chk("R7 read C", v, {dcu ? pc_in[7:4] : lc[7:4], dcl ? pc_in[3:0] : lc[3:0]});
    end

    wr(2'b11, 8'h92);
    rd(2'b11, v); chk("R8 92H readback", v, 8'h92);
    chk("R8 92H A in", pa_oe, 0); chk("R8 92H B in", pb_oe, 0); chk("R8 92H C out", pc_oe, 8'hFF);

    wr(2'b10, 8'hFF);
    wr(2'b11, 8'h0A);
    chk("R3 0AH clears bit5", pc_out, 8'hDF);

    lc = 8'hDF;
    for (int k = 0; k < 16; k++) begin
      wr(2'b11, {4'b0000, k[3:1], k[0]});
      lc[k[3:1]] = k[0];
      chk("R3 set/reset", pc_out, lc);
      chk("R6 pa_oe kept", pa_oe, 0); chk("R6 pc_oe kept", pc_oe, 8'hFF);
      rd(2'b11, v); chk("R6 ctl kept", v, 8'h92);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule